// File: doc/BRIEF.md
# Handshaked Serial Bit Transmitter

This block serialises one parallel word onto a single output line, one bit at a time, least significant bit first. It has no baud timer and no start, stop or parity framing. A ready input from the line paces every step of the transfer. A request input starts a transfer, and the block copies the word into a shift register when it accepts that request.

A four-state controller sequences the transfer. The states and their 2-bit encodings on `state_o` are:

| State | Code | Behaviour |
|---|---|---|
| `ST_IDLE` | `2'b00` | Waiting for a request. |
| `ST_LOAD` | `2'b01` | Word captured; waiting for the line. |
| `ST_SHIFT` | `2'b10` | Bits are driven onto the line. |
| `ST_STOP` | `2'b11` | Waiting for one more ready cycle. |

The transitions are:

- **start**: `ST_IDLE` goes to `ST_LOAD` when `load_i` is high.
- **go**: `ST_LOAD` goes to `ST_SHIFT` when `line_rdy_i` is high.
- **next bit**: `ST_SHIFT` stays in `ST_SHIFT` when `line_rdy_i` is high and the final bit is not yet on the line.
- **finish**: `ST_SHIFT` goes to `ST_STOP` when `line_rdy_i` is high and the final bit is on the line.
- **done**: `ST_STOP` goes to `ST_IDLE` when `line_rdy_i` is high.

When a transition's condition is false, the machine holds its state. No other transitions exist.

The current state is exported so that an external checker can follow the sequence.

Top module: `ser_tx_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the machine in `ST_IDLE` (`state_o`=00), drives `ser_o` high and `last_bit_o` low, and clears the bit counter, so the next word is sent in full.
- R2: In `ST_IDLE` (00), the machine moves to `ST_LOAD` (01) at an edge where `load_i` is high. Otherwise it stays in `ST_IDLE`.
- R3: In `ST_LOAD` (01), the machine moves to `ST_SHIFT` (10) at an edge where `line_rdy_i` is high. Otherwise it stays in `ST_LOAD`.
- R4: In `ST_SHIFT` (10), the machine moves to `ST_STOP` (11) only at an edge where `line_rdy_i` and `last_bit_o` are both high. Otherwise it stays in `ST_SHIFT`.
- R5: In `ST_STOP` (11), the machine returns to `ST_IDLE` at an edge where `line_rdy_i` is high. Otherwise it stays in `ST_STOP`.
- R6: The word is taken from `data_i` at the edge that leaves `ST_IDLE`. Later changes on `data_i` have no effect on the bits sent.
- R7: In `ST_SHIFT`, `ser_o` carries bit 0 of the captured word first, then bit 1, and so on up to bit W-1. The line moves to the next bit only after an edge with `line_rdy_i` high, and holds its bit while `line_rdy_i` is low.
- R8: Outside `ST_SHIFT`, `ser_o` is high.
- R9: `last_bit_o` is high exactly while the machine is in `ST_SHIFT` and bit W-1 is on the line.
- R10: `load_i` is ignored in every state other than `ST_IDLE`. A request raised during a transfer neither restarts it nor changes its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| load_i | input | 1 | Request: `data_i` holds a valid word. |
| line_rdy_i | input | 1 | The line can accept the next step. |
| data_i | input | W | Parallel word to send. |
| ser_o | output | 1 | Serial line; high when no bit is being sent. |
| state_o | output | 2 | Controller state code (see the state table). |
| last_bit_o | output | 1 | The final bit of the word is on the line. |

## Verification
All outputs are combinational functions of registers, so every effect of a stimulus shows up one rising edge after the inputs that caused it. A capture in `ST_IDLE` makes `state_o` read 01 after one edge. The first data bit appears on `ser_o` at the first edge after that with `line_rdy_i` high. Each further bit appears one ready edge later.

The bench changes inputs just after the falling edge and steps its reference model at the rising edge. It compares `state_o`, `ser_o` and `last_bit_o` at the next falling edge, exactly one edge after each stimulus. Directed words and random ready, request and data patterns then check both stalls and ignored inputs on every clock.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    // State encoding is exported on state_o and decoded by checkers.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_SHIFT = 2'b10,
        ST_STOP  = 2'b11
    } tx_state_e;

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
    import ser_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  logic      rdy_i,
    input  logic      last_i,
    output tx_state_e state_o,
    output logic      capture_o,
    output logic      advance_o
);

    tx_state_e state_q;
    tx_state_e state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (rdy_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (rdy_i && last_i) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (rdy_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Datapath strobes derived from the current state.
    always_comb begin
        capture_o = 1'b0;
        advance_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  capture_o = load_i;
            ST_LOAD:  ;
            ST_SHIFT: advance_o = rdy_i;
            ST_STOP:  ;
            default:  ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ser_tx_shreg.sv
module ser_tx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic         advance_i,
    input  logic [W-1:0] data_i,
    output logic         lsb_o
);

    logic [W-1:0] word_q;

    // Captured word moves toward bit 0; idle level fills from the top.
    always_ff @(posedge clk) begin
        if (rst)            word_q <= '1;
        else if (capture_i) word_q <= data_i;
        else if (advance_i) word_q <= {1'b1, word_q[W-1:1]};
    end

    assign lsb_o = word_q[0];

endmodule

// File: rtl/ser_tx_bitcnt.sv
module ser_tx_bitcnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic advance_i,
    output logic last_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            if (cnt_q == LAST_IDX) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
    import ser_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         line_rdy_i,
    input  logic [W-1:0] data_i,
    output logic         ser_o,
    output logic [1:0]   state_o,
    output logic         last_bit_o
);

    tx_state_e state;
    logic      capture;
    logic      advance;
    logic      lsb;
    logic      cnt_last;
    logic      in_shift;

    ser_tx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .rdy_i     (line_rdy_i),
        .last_i    (cnt_last),
        .state_o   (state),
        .capture_o (capture),
        .advance_o (advance)
    );

    ser_tx_shreg #(.W(W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .advance_i (advance),
        .data_i    (data_i),
        .lsb_o     (lsb)
    );

    ser_tx_bitcnt #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (capture),
        .advance_i (advance),
        .last_o    (cnt_last)
    );

    assign in_shift   = (state == ST_SHIFT);
    assign ser_o      = in_shift ? lsb : 1'b1;
    assign last_bit_o = in_shift & cnt_last;
    assign state_o    = state;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_rdy_i,
    input logic       ser_o,
    input logic [1:0] state_o,
    input logic       last_bit_o
);

    localparam logic [1:0] C_IDLE  = 2'b00;
    localparam logic [1:0] C_LOAD  = 2'b01;
    localparam logic [1:0] C_SHIFT = 2'b10;
    localparam logic [1:0] C_STOP  = 2'b11;

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
        state_o == C_IDLE |=> (state_o == C_IDLE || state_o == C_LOAD));

    assert_load_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_LOAD && !line_rdy_i) |=> state_o == C_LOAD);

    assert_load_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_LOAD && line_rdy_i) |=> state_o == C_SHIFT);

    assert_shift_exit_R4: assert property (@(posedge clk) disable iff (rst)
        state_o == C_SHIFT |=> (state_o == C_SHIFT || state_o == C_STOP));

    assert_shift_stay_R4: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_SHIFT && !last_bit_o) |=> state_o == C_SHIFT);

    assert_stop_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_STOP && line_rdy_i) |=> state_o == C_IDLE);

    assert_bit_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_SHIFT && !line_rdy_i) |=> $stable(ser_o));

    assert_line_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == C_STOP) |-> ser_o);

    assert_last_finish_R9: assert property (@(posedge clk) disable iff (rst)
        (last_bit_o && line_rdy_i) |=> state_o == C_STOP);

    assert_last_scope_R9: assert property (@(posedge clk) disable iff (rst)
        last_bit_o |-> state_o == C_SHIFT);

endmodule

bind ser_tx_top ser_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_rdy_i (line_rdy_i),
    .ser_o      (ser_o),
    .state_o    (state_o),
    .last_bit_o (last_bit_o)
);

// File: tb/tb_ser_tx_top.sv
`timescale 1ns/1ps
module tb_ser_tx_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic         line_rdy_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic         ser_o;
    logic [1:0]   state_o;
    logic         last_bit_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Reference model state: 0 idle, 1 load, 2 shift, 3 stop.
    int m_state = 0;
    bit m_bits[$];

    ser_tx_top #(.W(W)) dut (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .line_rdy_i (line_rdy_i),
        .data_i     (data_i),
        .ser_o      (ser_o),
        .state_o    (state_o),
        .last_bit_o (last_bit_o)
    );

    always #10 clk = ~clk;

    // Behavioural model stepped on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0;
            m_bits.delete();
        end else begin
            case (m_state)
                0: if (load_i) begin
                    m_bits.delete();
                    for (int i = 0; i < W; i++) m_bits.push_back(data_i[i]);
                    m_state = 1;
                end
                1: if (line_rdy_i) m_state = 2;
                2: if (line_rdy_i) begin
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) m_state = 3;
                end
                default: if (line_rdy_i) m_state = 0;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare all outputs against the model after every edge.
    always @(negedge clk) begin
        if (!done) begin
            check("R2/R3/R4/R5 state_o", int'(state_o), m_state);
            if (m_state == 2)
                check("R7 ser_o bit order", int'(ser_o), int'(m_bits[0]));
            else
                check("R8 ser_o idle high", int'(ser_o), 1);
            check("R9 last_bit_o", int'(last_bit_o),
                  (m_state == 2 && m_bits.size() == 1) ? 1 : 0);
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    // mode 0: always ready, 1: random, 2: ready every third cycle
    function automatic logic rdy_pick(input int mode, input int k);
        case (mode)
            0:       return 1'b1;
            1:       return 1'($urandom_range(0, 1));
            default: return (k % 3 == 2);
        endcase
    endfunction

    // Send one word; data_i scrambled and load_i re-raised after capture (R6, R10).
    task automatic send_word(input logic [W-1:0] w, input int mode, input bit poke_load);
        int k = 0;
        load_i     = 1'b1;
        data_i     = w;
        line_rdy_i = 1'b0;
        step();
        load_i = 1'b0;
        while (m_state != 0 && k < 200) begin
            data_i     = W'($urandom);
            load_i     = poke_load ? 1'($urandom_range(0, 1)) : 1'b0;
            line_rdy_i = rdy_pick(mode, k);
            k++;
            step();
        end
        load_i     = 1'b0;
        line_rdy_i = 1'b0;
    endtask

    initial begin
        step();
        step();
        rst = 1'b0;
        // R1: reset values
        check("R1 state after reset", int'(state_o), 0);
        check("R1 ser_o after reset", int'(ser_o), 1);
        check("R1 last_bit_o after reset", int'(last_bit_o), 0);

        // R2: no request keeps idle even with ready high
        line_rdy_i = 1'b1;
        step();
        step();
        check("R2 idle without load", int'(state_o), 0);
        line_rdy_i = 1'b0;

        // R3: load state waits for ready
        load_i = 1'b1;
        data_i = 8'h3C;
        step();
        load_i = 1'b0;
        step();
        step();
        check("R3 load holds without ready", int'(state_o), 1);
        line_rdy_i = 1'b1;
        step();
        check("R3 shift after ready", int'(state_o), 2);
        check("R7 first bit is bit0", int'(ser_o), 0);
        // R1: reset mid-transfer, then a full word must follow
        rst = 1'b1;
        step();
        rst = 1'b0;
        line_rdy_i = 1'b0;
        check("R1 reset mid transfer", int'(state_o), 0);

        send_word(8'hA5, 0, 1'b0);
        send_word(8'h00, 0, 1'b0);
        send_word(8'hFF, 2, 1'b0);
        send_word(8'h81, 1, 1'b1);
        send_word(8'h7E, 2, 1'b1);
        for (int n = 0; n < 40; n++)
            send_word(W'($urandom), n % 3, n[0]);

        // R10: load held high continuously gives back-to-back words
        load_i = 1'b1;
        for (int n = 0; n < 60; n++) begin
            data_i     = W'($urandom);
            line_rdy_i = 1'($urandom_range(0, 1));
            step();
        end
        load_i = 1'b0;
        line_rdy_i = 1'b1;
        for (int n = 0; n < 20; n++) step();
        check("R5 back to idle", int'(state_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        done = 1'b1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule